// File: doc/BRIEF.md
# Clock Source and Low-Power Mode Controller

This block selects where the system clock comes from and manages the low-power clock modes. It does no clock gating of its own. It produces a single-cycle clock-enable stream, `sys_ce`, on the fast fabric clock, and downstream logic advances only in the cycles where that enable is high. The two analog sources are modelled as tick inputs: a crystal-rate reference tick (nominally 32 kHz) and a high-rate VCO tick. Software writes a small register port. Address 0 holds the 8-bit multiplier value that is passed on to the PLL. Address 1 holds a 2-bit source select and three mode bits: halt oscillator, halt VCO and crystal bypass.

Four sources can drive the system enable when bypass is off:
- the VCO tick itself;
- the VCO tick divided by two;
- the VCO tick divided by four;
- an enable stream at twice the crystal rate, made by adding a midpoint pulse halfway through each measured reference period.

The dividers are taps on a free-running counter. A new select value is adopted only when that counter wraps, so no enable period is ever cut short.

A settle counter runs on reference ticks and raises `vco_ready` once the VCO has run for a programmable number of ticks. The default count is 328, roughly 10 ms. Setting the halt-VCO bit clears the counter. A request to leave bypass while `vco_ready` is low is held, and it takes effect on the first reference tick after `vco_ready` is seen high. After power-up the block runs in bypass from the crystal with the VCO running, so a later move to the fast source is quick.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset, `sys_ce` and `vco_ready` are 0 and `pll_mult` equals `MULT_INIT`. The control state comes up with bypass=1, halt VCO=0, halt oscillator=0 and select=00.
- R2: A write to address 0 loads `wr_data` into `pll_mult`, and the new value is visible on the next cycle. A write to address 1 loads the control fields at these bit positions: [1:0] source select, [2] halt oscillator, [3] halt VCO, [4] bypass.
- R3: While the halt-oscillator bit is 1, `sys_ce` is held at 0 whatever the other bits are.
- R4: While bypass is in effect, `sys_ce` pulses once for each reference tick, one cycle after that tick.
- R5: `vco_ready` rises on the `SETTLE_TICKS`-th reference tick counted while the VCO runs. While the halt-VCO bit is 1, the count is cleared and `vco_ready` is held at 0.
- R6: Clearing the bypass bit while `vco_ready` is 0 leaves bypass in effect. Bypass is released on the first reference tick at which `vco_ready` is already 1. Setting the bypass bit takes effect on the next cycle.
- R7: With select 00 and bypass released, `sys_ce` pulses once for each VCO tick.
- R8: With select 01, `sys_ce` pulses on every second VCO tick. With select 10, it pulses on every fourth VCO tick.
- R9: With select 11, `sys_ce` pulses at twice the reference rate: once on each reference tick and once midway through each period, where the period is the last measured interval between ticks.
- R10: A new select value is adopted only on a VCO tick that wraps the divider counter, or while the VCO is halted. After a change, the gap between two `sys_ce` pulses is never shorter than the period of the newly selected source.
- R11: While the halt-VCO bit is 1, VCO ticks are ignored, so a VCO-derived source yields no `sys_ce` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock on which all ticks are sampled |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per crystal period |
| vco_tick | input | 1 | One-cycle pulse per VCO period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address: 0 multiplier, 1 control |
| wr_data | input | 8 | Register write data |
| sys_ce | output | 1 | Registered system clock-enable pulse |
| vco_ready | output | 1 | VCO settle interval has elapsed |
| pll_mult | output | 8 | Multiplier value passed to the PLL |

## Verification
The bench builds the block with `SETTLE_TICKS` set to 8 in place of 328. With that value the settle count completes in about 80 cycles, so a single run can cover a settle interval that restarts after a halt, and also the held release of bypass. The reference tick arrives every 10 cycles and the VCO tick every 2 cycles. Every source rate is therefore distinct in a 200-cycle count, and the midpoint pulses of the doubled source fall on whole cycles.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int SEL_W      = 2;
  localparam int DIV_STAGES = 2;
  localparam int DATA_W     = 8;
  localparam logic ADDR_MULT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic             bypass;
    logic             halt_vco;
    logic             halt_osc;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam ctrl_t CTRL_INIT = '{bypass: 1'b1, halt_vco: 1'b0,
                                  halt_osc: 1'b0, sel: '0};
endpackage

// File: rtl/cm_regs.sv
module cm_regs
  import cm_pkg::*;
#(
  parameter logic [DATA_W-1:0] MULT_INIT = 8'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ref_g,
  input  logic              vco_ready,
  output ctrl_t             ctrl_q,
  output logic              byp_eff,
  output logic [DATA_W-1:0] mult_q
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_INIT;
      mult_q  <= MULT_INIT;
      byp_eff <= CTRL_INIT.bypass;
    end else begin
      if (wr_en && (wr_addr == ADDR_MULT))
        mult_q <= wr_data;
      if (ctrl_wr)
        ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (ctrl_wr && wr_data[CTRL_W-1])
        byp_eff <= 1'b1;
      else if (!ctrl_q.bypass && ref_g && vco_ready)
        byp_eff <= 1'b0;
    end
  end
endmodule

// File: rtl/cm_settle.sv
module cm_settle #(
  parameter int SETTLE_TICKS = 328
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_vco,
  input  logic ref_g,
  output logic vco_ready
);
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || halt_vco) begin
      cnt       <= '0;
      vco_ready <= 1'b0;
    end else if (ref_g && (cnt != LIMIT)) begin
      cnt       <= cnt_nxt;
      vco_ready <= (cnt_nxt == LIMIT);
    end
  end
endmodule

// File: rtl/cm_vco_div.sv
module cm_vco_div #(
  parameter int STAGES = 2,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vco_g,
  input  logic             halt_vco,
  input  logic [SEL_W-1:0] req_sel,
  output logic [STAGES:0]  taps,
  output logic             wrap,
  output logic [SEL_W-1:0] act_sel
);
  logic [STAGES-1:0] cnt;

  assign taps[0] = vco_g;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign taps[k] = vco_g && (&cnt[k-1:0]);
  end
  assign wrap = taps[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_sel <= '0;
    end else begin
      if (vco_g)
        cnt <= cnt + 1'b1;
      if (wrap || halt_vco)
        act_sel <= req_sel;
    end
  end
endmodule

// File: rtl/cm_ref_dbl.sv
module cm_ref_dbl #(
  parameter int PER_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_g,
  output logic dbl_tick
);
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] half;
  logic [PER_W-1:0] per_nxt;
  assign per_nxt = per_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      half    <= '0;
    end else if (ref_g) begin
      per_cnt <= '0;
      half    <= per_nxt >> 1;
    end else if (per_cnt != '1) begin
      per_cnt <= per_nxt;
    end
  end

  assign dbl_tick = ref_g || ((half != '0) && (per_nxt == half));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import cm_pkg::*;
#(
  parameter int                SETTLE_TICKS = 328,
  parameter int                PER_W        = 16,
  parameter logic [DATA_W-1:0] MULT_INIT    = 8'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              vco_tick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sys_ce,
  output logic              vco_ready,
  output logic [DATA_W-1:0] pll_mult
);
  ctrl_t                ctrl_q;
  logic                 byp_eff;
  logic                 ref_g;
  logic                 vco_g;
  logic                 dbl_tick;
  logic [DIV_STAGES:0]  taps;
  logic                 vco_wrap;
  logic [SEL_W-1:0]     act_sel;
  logic                 src_pulse;

  assign ref_g = ref_tick && !ctrl_q.halt_osc;
  assign vco_g = vco_tick && !ctrl_q.halt_vco && !ctrl_q.halt_osc;

  cm_regs #(.MULT_INIT(MULT_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ref_g(ref_g), .vco_ready(vco_ready),
    .ctrl_q(ctrl_q), .byp_eff(byp_eff), .mult_q(pll_mult)
  );

  cm_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst(rst), .halt_vco(ctrl_q.halt_vco),
    .ref_g(ref_g), .vco_ready(vco_ready)
  );

  cm_vco_div #(.STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .vco_g(vco_g), .halt_vco(ctrl_q.halt_vco),
    .req_sel(ctrl_q.sel), .taps(taps), .wrap(vco_wrap), .act_sel(act_sel)
  );

  cm_ref_dbl #(.PER_W(PER_W)) u_dbl (
    .clk(clk), .rst(rst), .ref_g(ref_g), .dbl_tick(dbl_tick)
  );

  always_comb begin
    src_pulse = dbl_tick;
    for (int k = 0; k <= DIV_STAGES; k++)
      if (act_sel == SEL_W'(k))
        src_pulse = taps[k];
  end

  always_ff @(posedge clk) begin
    if (rst)
      sys_ce <= 1'b0;
    else
      sys_ce <= !ctrl_q.halt_osc && (byp_eff ? ref_g : src_pulse);
  end
endmodule

// File: rtl/cm_check.sv
module cm_check #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_ce,
  input logic             vco_ready,
  input logic             halt_osc,
  input logic             halt_vco,
  input logic             byp_eff,
  input logic             ref_g,
  input logic             vco_wrap,
  input logic [SEL_W-1:0] act_sel
);
  p_ce_low_halt_osc_r3: assert property (@(posedge clk) disable iff (rst)
    halt_osc |=> !sys_ce);

  p_ready_low_halt_vco_r5: assert property (@(posedge clk) disable iff (rst)
    halt_vco |=> !vco_ready);

  p_ready_rise_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_ready) |-> $past(ref_g));

  p_bypass_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(byp_eff) |-> ($past(vco_ready) && $past(ref_g)));

  p_sel_at_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_sel) |-> ($past(vco_wrap) || $past(halt_vco)));
endmodule

bind clkmode_ctrl cm_check #(.SEL_W(cm_pkg::SEL_W)) u_cm_check (
  .clk(clk), .rst(rst), .sys_ce(sys_ce), .vco_ready(vco_ready),
  .halt_osc(ctrl_q.halt_osc), .halt_vco(ctrl_q.halt_vco),
  .byp_eff(byp_eff), .ref_g(ref_g), .vco_wrap(vco_wrap), .act_sel(act_sel)
);

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 10;
  localparam int SETTLE     = 8;
  localparam logic [7:0] MINIT = 8'd64;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic vco_tick = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic sys_ce;
  logic vco_ready;
  logic [7:0] pll_mult;

  int checks = 0;
  int failures = 0;
  int refcnt = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmode_ctrl #(.SETTLE_TICKS(SETTLE), .PER_W(16), .MULT_INIT(MINIT)) i_clkmode_ctrl (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_ce(sys_ce), .vco_ready(vco_ready), .pll_mult(pll_mult)
  );

  // tick sources: reference every REF_P cycles, VCO every 2 cycles
  always @(negedge clk) begin
    if (rst) begin
      refcnt   <= 0;
      ref_tick <= 1'b0;
      vco_tick <= 1'b0;
    end else begin
      refcnt   <= (refcnt == REF_P-1) ? 0 : refcnt + 1;
      ref_tick <= (refcnt == REF_P-1);
      vco_tick <= ~vco_tick;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_ce(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_ce) cnt++;
    end
  endtask

  task automatic check_rate(input string tag, input int act, input int exp);
    check((act >= exp-2) && (act <= exp+2), tag, act, exp);
  endtask

  // R1 reset state, R5 settle timing, R4 bypass rate at power-up
  task automatic t_reset_and_settle();
    int c;
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    check(sys_ce == 1'b0, "R1 sys_ce after reset", sys_ce, 0);
    check(vco_ready == 1'b0, "R1 vco_ready after reset", vco_ready, 0);
    check(pll_mult == MINIT, "R1 pll_mult after reset", pll_mult, MINIT);
    wait_cyc(40);
    check(vco_ready == 1'b0, "R5 ready low before settle", vco_ready, 0);
    wait_cyc(60);
    check(vco_ready == 1'b1, "R5 ready high after settle", vco_ready, 1);
    count_ce(200, c);
    check_rate("R4 R1 default bypass follows ref", c, 200/REF_P);
  endtask

  // R2 multiplier register
  task automatic t_mult_write();
    write_reg(1'b0, 8'hA5);
    check(pll_mult == 8'hA5, "R2 pll_mult write", pll_mult, 8'hA5);
  endtask

  // R5 halt clears ready, R6 bypass release held until ready, R7 VCO rate
  task automatic t_bypass_pending();
    int c;
    write_reg(1'b1, 8'h18);   // bypass=1 halt_vco=1
    wait_cyc(3);
    check(vco_ready == 1'b0, "R5 ready cleared by halt_vco", vco_ready, 0);
    write_reg(1'b1, 8'h00);   // bypass=0, sel 00
    count_ce(40, c);
    check((c >= 2) && (c <= 6), "R6 bypass held while not ready", c, 4);
    wait_cyc(100);
    check(vco_ready == 1'b1, "R5 ready after restart", vco_ready, 1);
    count_ce(200, c);
    check_rate("R7 R6 VCO source after release", c, 100);
  endtask

  // R8 R9 divided and doubled sources
  task automatic t_sources();
    int c;
    write_reg(1'b1, 8'h01);
    wait_cyc(10);
    count_ce(200, c);
    check_rate("R8 select 01 VCO/2", c, 50);
    write_reg(1'b1, 8'h02);
    wait_cyc(10);
    count_ce(200, c);
    check_rate("R8 select 10 VCO/4", c, 25);
    write_reg(1'b1, 8'h03);
    wait_cyc(30);
    count_ce(200, c);
    check_rate("R9 select 11 twice ref", c, 2*200/REF_P);
  endtask

  // R10 no shortened period across a select change
  task automatic t_switch_gap();
    int last, min_gap;
    write_reg(1'b1, 8'h02);
    wait_cyc(20);
    write_reg(1'b1, 8'h01);
    last = -1; min_gap = 1000;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sys_ce) begin
        if (last >= 0 && (i - last) < min_gap) min_gap = i - last;
        last = i;
      end
    end
    check(min_gap >= 4, "R10 min gap after select change", min_gap, 4);
  endtask

  // R11 halted VCO, R3 halted oscillator
  task automatic t_halts();
    int c;
    write_reg(1'b1, 8'h08);   // sel 00, halt_vco, bypass 0
    wait_cyc(4);
    count_ce(100, c);
    check(c == 0, "R11 no pulses with VCO halted", c, 0);
    write_reg(1'b1, 8'h14);   // halt_osc + bypass
    wait_cyc(2);
    count_ce(100, c);
    check(c == 0, "R3 no pulses with oscillator halted", c, 0);
    write_reg(1'b1, 8'h10);   // bypass only, resume
    wait_cyc(4);
    count_ce(200, c);
    check_rate("R4 R2 bypass resumes after control write", c, 200/REF_P);
  endtask

  initial begin
    t_reset_and_settle();
    t_mult_write();
    t_bypass_pending();
    t_sources();
    t_switch_gap();
    t_halts();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule